// File: doc/BRIEF.md
# Descriptor Ring Queue Engine

This block serves one endpoint of a device-side transfer controller. Software builds a circular chain of 16-byte transfer descriptors in memory, sets the ownership bit of each ready descriptor, and starts the engine at the ring's first address. The engine reads each descriptor as four 32-bit words. It checks the ownership bit and an 8-bit checksum. It then hands the buffer address, byte count and a zero-length-packet request to an external data mover. When the mover reports completion, the engine clears the ownership bit in memory, pulses a done signal and follows the descriptor's next pointer. Addresses are 36 bits wide. The upper nibbles of the buffer and next pointers come from an extension halfword in the descriptor.

Descriptor layout. Each descriptor is four little-endian words at a word-aligned byte address, with word k at address+4k.
- Word 0: bits [7:0] hold the flags, bits [15:8] hold the checksum and bits [31:16] hold the byte count.
- Word 1: the low 32 bits of the next pointer.
- Word 2: the low 32 bits of the buffer address.
- Word 3: bits [3:0] hold buffer address bits [35:32], bits [7:4] hold next pointer bits [35:32], and bit 21 requests a zero-length packet.

Flag bits are: bit 0 hardware ownership, bit 1 buffer-list present (carried through, not acted on), bit 2 bypass, and bit 7 interrupt on completion.

The engine has pulse controls for start, stop and resume, and a start-address input. It exposes the current descriptor address and an active flag. A descriptor whose ownership bit is clear parks the engine until software resumes it. Checksum and length faults raise a pulse and halt the queue, leaving the descriptor owned by hardware so that software can repair it and resume.

Top module: `dring_engine`

## Requirements
- R1: After reset, `active` is 0, `cur_addr` is 0, no memory access or transfer request is made, and no event pulse is raised.
- R2: A start pulse while idle loads `cur_addr` from `start_addr` and raises `active` on the next cycle. The engine then reads the four words at `cur_addr`, +4, +8 and +12, in that order.
- R3: A fetched descriptor with flag bit 0 clear stalls the engine. `active` stays 1, `cur_addr` is held, and nothing is transferred or written. A resume pulse makes the engine fetch the same descriptor again.
- R4: A descriptor is valid when the 8-bit sum of its 16 bytes, with byte 1 taken as zero and flag bit 0 taken as one, plus byte 1, equals 0xFF. On a mismatch the engine pulses `cksum_err`, clears `active`, holds `cur_addr` and does not write the descriptor.
- R5: A valid owned descriptor drives `xfer_valid` with `xfer_addr` = {word3[3:0], word2}, `xfer_len` = word0[31:16] and `xfer_zlp` = word3 bit 21. The request holds until `xfer_done`.
- R6: When a descriptor finishes, word 0 is written back with bit 0 cleared and all other bits unchanged. `done_pulse` is then raised with `done_ioc` equal to flag bit 7, and `cur_addr` becomes {word3[7:4], word1}.
- R7: An owned, valid descriptor with flag bit 2 set moves no data. It is written back and reported as in R6.
- R8: When `tx_mode` is 1, a descriptor with a byte count of zero raises `len_err`, moves no data, clears `active`, holds `cur_addr` and keeps ownership. When `tx_mode` is 0, a zero byte count is transferred normally.
- R9: A stop pulse during a descriptor lets that descriptor finish. `active` then clears with `cur_addr` at the next descriptor. A stop pulse while stalled clears `active` on the next cycle.
- R10: Faults are tested in this order: ownership, then checksum, then bypass, then length. A bypassed descriptor with a bad checksum therefore reports `cksum_err`.
- R11: At most one of `done_pulse`, `cksum_err` and `len_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_mode | input | 1 | 1 for the transmit direction (enables the zero-length check) |
| cmd_start | input | 1 | Start pulse |
| cmd_stop | input | 1 | Stop pulse |
| cmd_resume | input | 1 | Resume pulse |
| start_addr | input | ADDR_W | Ring start address |
| cur_addr | output | ADDR_W | Address of the descriptor being worked on or waited on |
| active | output | 1 | Queue running or stalled |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read request |
| xfer_valid | output | 1 | Transfer request to the data mover |
| xfer_addr | output | ADDR_W | Buffer address |
| xfer_len | output | 16 | Byte count |
| xfer_zlp | output | 1 | Zero-length packet requested after the data |
| xfer_done | input | 1 | Data mover completion pulse |
| done_pulse | output | 1 | A descriptor finished |
| done_ioc | output | 1 | Interrupt-on-completion flag of the finished descriptor |
| cksum_err | output | 1 | Checksum mismatch pulse |
| len_err | output | 1 | Zero transmit length pulse |

## Verification
Several properties are checked on every cycle: the idle engine stays silent, every write to memory releases ownership at the current address, a write-back is always followed by a done pulse, the pointer stays fixed while a transfer is in flight, and the event pulses never overlap. Other behaviours only show up in the bench's scenarios because they depend on descriptor contents. These include wrap-around of the ring, skipping a bypassed entry, and the 36-bit pointer extension. They also include the stall and resume on a descriptor re-armed by software, fault precedence, zero-length handling in both directions, and a stop that lets the descriptor in flight finish.

// File: rtl/dring_pkg.sv
package dring_pkg;

  localparam int DESC_WORDS = 4;
  localparam int DESC_BITS  = 32 * DESC_WORDS;

  // flag byte bit positions
  localparam int FLG_OWN  = 0;
  localparam int FLG_SKIP = 2;
  localparam int FLG_IOC  = 7;
  // zero-length request bit inside the descriptor
  localparam int ZLP_BIT  = 117;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_XFER  = 3'd2,
    ST_WB    = 3'd3,
    ST_WAIT  = 3'd4
  } seq_st_t;

  // byte sum with the checksum byte zeroed and ownership forced to one
  function automatic logic [7:0] desc_sum(input logic [DESC_BITS-1:0] d);
    logic [7:0] acc;
    acc = 8'h00;
    for (int i = 0; i < DESC_BITS / 8; i++) begin
      logic [7:0] b;
      b = d[8*i +: 8];
      if (i == 1) b = 8'h00;
      if (i == 0) b[0] = 1'b1;
      acc = acc + b;
    end
    return acc;
  endfunction

  function automatic logic desc_sum_ok(input logic [DESC_BITS-1:0] d);
    logic [7:0] t;
    t = desc_sum(d) + d[15:8];
    return t == 8'hFF;
  endfunction

endpackage

// File: rtl/dring_fetch.sv
module dring_fetch
  import dring_pkg::*;
#(
  parameter int ADDR_W = 36
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [ADDR_W-1:0]    base,
  input  logic [31:0]          rdata,
  output logic                 rd_req,
  output logic [ADDR_W-1:0]    rd_addr,
  output logic [DESC_BITS-1:0] desc,
  output logic                 ready
);
  localparam int CNT_W = $clog2(DESC_WORDS) + 1;

  logic [CNT_W-1:0]   iss;
  logic               run;
  logic               cap_v;
  logic [CNT_W-2:0]   cap_i;

  assign rd_req  = run && (iss < CNT_W'(DESC_WORDS));
  assign rd_addr = base + ADDR_W'({iss[CNT_W-2:0], 2'b00});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss   <= '0;
      run   <= 1'b0;
      cap_v <= 1'b0;
      cap_i <= '0;
      ready <= 1'b0;
      desc  <= '0;
    end else begin
      ready <= 1'b0;
      cap_v <= rd_req;
      cap_i <= iss[CNT_W-2:0];
      if (rd_req) iss <= iss + 1'b1;
      if (cap_v) begin
        desc[{cap_i, 5'b00000} +: 32] <= rdata;
        if (cap_i == (CNT_W-1)'(DESC_WORDS - 1)) begin
          ready <= 1'b1;
          run   <= 1'b0;
        end
      end
      if (go) begin
        run <= 1'b1;
        iss <= '0;
      end
    end
  end
endmodule

// File: rtl/dring_cksum.sv
module dring_cksum
  import dring_pkg::*;
(
  input  logic [DESC_BITS-1:0] desc,
  output logic                 ok
);
  assign ok = desc_sum_ok(desc);
endmodule

// File: rtl/dring_seq.sv
module dring_seq
  import dring_pkg::*;
#(
  parameter int ADDR_W = 36
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_mode,
  input  logic                 cmd_start,
  input  logic                 cmd_stop,
  input  logic                 cmd_resume,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic                 ready,
  input  logic [DESC_BITS-1:0] desc,
  input  logic                 ck_ok,
  input  logic                 xfer_done,
  output logic                 go,
  output logic [ADDR_W-1:0]    cur_addr,
  output logic                 active,
  output logic                 xfer_valid,
  output logic [ADDR_W-1:0]    xfer_addr,
  output logic [15:0]          xfer_len,
  output logic                 xfer_zlp,
  output logic                 wb_req,
  output logic [31:0]          wb_data,
  output logic                 done_pulse,
  output logic                 done_ioc,
  output logic                 ck_err,
  output logic                 len_err
);
  localparam int HI_W = ADDR_W - 32;

  seq_st_t st;
  logic    stop_pend;

  function automatic logic [ADDR_W-1:0] next_ptr(input logic [DESC_BITS-1:0] d);
    return {d[100 +: HI_W], d[63:32]};
  endfunction

  function automatic logic [ADDR_W-1:0] buf_ptr(input logic [DESC_BITS-1:0] d);
    return {d[96 +: HI_W], d[95:64]};
  endfunction

  logic [7:0] flag;
  logic       unused_bits;
  assign flag        = desc[7:0];
  assign unused_bits = ^{desc[127:118], desc[116:104]};

  assign active     = (st != ST_IDLE);
  assign xfer_valid = (st == ST_XFER);
  assign xfer_addr  = buf_ptr(desc);
  assign xfer_len   = desc[31:16];
  assign xfer_zlp   = desc[ZLP_BIT];
  assign wb_req     = (st == ST_WB);
  assign wb_data    = {desc[31:1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      stop_pend  <= 1'b0;
      cur_addr   <= '0;
      go         <= 1'b0;
      done_pulse <= 1'b0;
      done_ioc   <= 1'b0;
      ck_err     <= 1'b0;
      len_err    <= 1'b0;
    end else begin
      go         <= 1'b0;
      done_pulse <= 1'b0;
      ck_err     <= 1'b0;
      len_err    <= 1'b0;
      if (cmd_stop && st != ST_IDLE) stop_pend <= 1'b1;
      case (st)
        ST_IDLE: begin
          if (cmd_start) begin
            cur_addr  <= start_addr;
            st        <= ST_FETCH;
            go        <= 1'b1;
            stop_pend <= 1'b0;
          end else if (cmd_resume) begin
            st        <= ST_FETCH;
            go        <= 1'b1;
            stop_pend <= 1'b0;
          end
        end
        ST_FETCH: begin
          if (ready) begin
            if (!flag[FLG_OWN]) begin
              st <= (stop_pend || cmd_stop) ? ST_IDLE : ST_WAIT;
            end else if (!ck_ok) begin
              ck_err <= 1'b1;
              st     <= ST_IDLE;
            end else if (flag[FLG_SKIP]) begin
              st <= ST_WB;
            end else if (tx_mode && xfer_len == 16'd0) begin
              len_err <= 1'b1;
              st      <= ST_IDLE;
            end else begin
              st <= ST_XFER;
            end
          end
        end
        ST_XFER: begin
          if (xfer_done) st <= ST_WB;
        end
        ST_WB: begin
          done_pulse <= 1'b1;
          done_ioc   <= flag[FLG_IOC];
          cur_addr   <= next_ptr(desc);
          if (stop_pend || cmd_stop) begin
            st <= ST_IDLE;
          end else begin
            st <= ST_FETCH;
            go <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (cmd_stop) begin
            st <= ST_IDLE;
          end else if (cmd_resume) begin
            st <= ST_FETCH;
            go <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dring_engine.sv
module dring_engine
  import dring_pkg::*;
#(
  parameter int ADDR_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_mode,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_resume,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              active,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              xfer_valid,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [15:0]       xfer_len,
  output logic              xfer_zlp,
  input  logic              xfer_done,
  output logic              done_pulse,
  output logic              done_ioc,
  output logic              cksum_err,
  output logic              len_err
);
  logic                 fetch_go;
  logic                 rd_req;
  logic [ADDR_W-1:0]    rd_addr;
  logic [DESC_BITS-1:0] desc;
  logic                 desc_ready;
  logic                 ck_ok;
  logic                 wb_req;
  logic [31:0]          wb_data;

  dring_fetch #(.ADDR_W(ADDR_W)) fetch_i (
    .clk(clk), .rst_n(rst_n), .go(fetch_go), .base(cur_addr),
    .rdata(mem_rdata), .rd_req(rd_req), .rd_addr(rd_addr),
    .desc(desc), .ready(desc_ready)
  );

  dring_cksum cksum_i (.desc(desc), .ok(ck_ok));

  dring_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_resume(cmd_resume),
    .start_addr(start_addr), .ready(desc_ready), .desc(desc), .ck_ok(ck_ok),
    .xfer_done(xfer_done), .go(fetch_go), .cur_addr(cur_addr),
    .active(active), .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
    .xfer_len(xfer_len), .xfer_zlp(xfer_zlp), .wb_req(wb_req),
    .wb_data(wb_data), .done_pulse(done_pulse), .done_ioc(done_ioc),
    .ck_err(cksum_err), .len_err(len_err)
  );

  assign mem_req   = rd_req | wb_req;
  assign mem_we    = wb_req;
  assign mem_addr  = wb_req ? cur_addr : rd_addr;
  assign mem_wdata = wb_data;
endmodule

// File: rtl/dring_engine_chk.sv
module dring_engine_chk #(
  parameter int ADDR_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_mode,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              active,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              xfer_valid,
  input logic [15:0]       xfer_len,
  input logic              xfer_done,
  input logic              done_pulse,
  input logic              cksum_err,
  input logic              len_err,
  input logic              desc_ready,
  input logic              ck_ok
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!mem_req && !xfer_valid));

  // R6
  own_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata[0] == 1'b0 && mem_addr == cur_addr));

  // R6
  wb_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> done_pulse);

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> $stable(cur_addr));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_done) |=> xfer_valid);

  // R8
  tx_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && tx_mode) |-> (xfer_len != 16'd0));

  // R4
  cksum_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cksum_err |-> ($past(desc_ready && !ck_ok) && !active));

  // R11
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_pulse, cksum_err, len_err}));
endmodule

bind dring_engine dring_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .cur_addr(cur_addr),
  .active(active), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .xfer_valid(xfer_valid), .xfer_len(xfer_len),
  .xfer_done(xfer_done), .done_pulse(done_pulse), .cksum_err(cksum_err),
  .len_err(len_err), .desc_ready(desc_ready), .ck_ok(ck_ok)
);

// File: tb/dring_engine_tb_top.sv
module dring_engine_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 36;
  localparam logic [1:0] K_XFER = 2'd0, K_DONE = 2'd1, K_CKE = 2'd2, K_LNE = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_mode = 1'b1;
  logic cmd_start = 1'b0, cmd_stop = 1'b0, cmd_resume = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [ADDR_W-1:0] cur_addr, mem_addr, xfer_addr;
  logic active, mem_req, mem_we, xfer_valid, xfer_zlp, done_pulse, done_ioc;
  logic cksum_err, len_err;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [15:0] xfer_len;
  logic xfer_done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dring_engine #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_resume(cmd_resume), .start_addr(start_addr),
    .cur_addr(cur_addr), .active(active), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_zlp(xfer_zlp), .xfer_done(xfer_done), .done_pulse(done_pulse),
    .done_ioc(done_ioc), .cksum_err(cksum_err), .len_err(len_err)
  );

  // memory model: 64 words, one-cycle read latency
  logic [31:0] mem [64];
  logic        tb_we = 1'b0;
  logic [5:0]  tb_idx = '0;
  logic [31:0] tb_dat = '0;
  logic [31:0] w0_save [64];

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    else if (tb_we) mem[tb_idx] <= tb_dat;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:2]];
  end

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard
  logic [65:0] exp_q [$];
  string       tag_q [$];

  task automatic expect_ev(input logic [1:0] k, input logic [63:0] d, input string tag);
    exp_q.push_back({k, d});
    tag_q.push_back(tag);
  endtask

  task automatic observe(input logic [1:0] k, input logic [63:0] d);
    logic [65:0] e;
    string t;
    if (exp_q.size() == 0) begin
      check(1'b0, "R11", "unexpected event", {62'b0, k}, 64'hFFFF);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(e[65:64] == k, t, "event kind", {62'b0, k}, {62'b0, e[65:64]});
      check(e[63:0] == d, t, "event data", d, e[63:0]);
    end
  endtask

  function automatic logic [63:0] xf(input bit z, input logic [15:0] l, input logic [35:0] a);
    return {11'b0, z, l, a};
  endfunction
  function automatic logic [63:0] dn(input bit i, input logic [35:0] a);
    return {27'b0, i, a};
  endfunction

  // monitor
  initial begin
    logic prev_xv;
    prev_xv = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (xfer_valid && !prev_xv) observe(K_XFER, xf(xfer_zlp, xfer_len, xfer_addr));
        if (done_pulse) observe(K_DONE, dn(done_ioc, cur_addr));
        if (cksum_err) observe(K_CKE, {28'b0, cur_addr});
        if (len_err) observe(K_LNE, {28'b0, cur_addr});
      end
      prev_xv = xfer_valid;
    end
  end

  // data mover model: completes three cycles after a request appears
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (xfer_done) begin
        xfer_done = 1'b0;
      end else if (xfer_valid) begin
        cnt++;
        if (cnt == 3) begin
          xfer_done = 1'b1;
          cnt = 0;
        end
      end
    end
  end

  task automatic put_desc(input int base, input logic [7:0] flag, input logic [15:0] len,
                          input logic [35:0] nxt, input logic [35:0] bufa,
                          input bit zlp, input bit bad);
    logic [31:0] w [4];
    logic [7:0] s;
    logic [7:0] chk;
    w[1] = nxt[31:0];
    w[2] = bufa[31:0];
    w[3] = {8'h00, 2'b00, zlp, 5'b0, 8'h00, nxt[35:32], bufa[35:32]};
    s = (flag | 8'h01) + len[7:0] + len[15:8];
    for (int k = 1; k < 4; k++) s = s + w[k][7:0] + w[k][15:8] + w[k][23:16] + w[k][31:24];
    chk = 8'hFF - s;
    if (bad) chk = chk + 8'h01;
    w[0] = {len, chk, flag};
    w0_save[base/4] = w[0];
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      tb_we = 1'b1;
      tb_idx = 6'(base/4 + k);
      tb_dat = w[k];
    end
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) cmd_start = 1'b1;
    else if (which == 1) cmd_stop = 1'b1;
    else cmd_resume = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    cmd_stop = 1'b0;
    cmd_resume = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, req, "expected events outstanding", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    #(CLK_P * 100000);
    check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
    if (!finished) begin
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = '0;
      w0_save[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(active == 1'b0, "R1", "active after reset", {63'b0, active}, 64'd0);
    check(cur_addr == '0, "R1", "cur_addr after reset", {28'b0, cur_addr}, 64'd0);
    check(!mem_req && !xfer_valid, "R1", "no access after reset", {62'b0, mem_req, xfer_valid}, 64'd0);
    check(!done_pulse && !cksum_err && !len_err, "R1", "no pulses after reset",
          {61'b0, done_pulse, cksum_err, len_err}, 64'd0);

    // ring of three: normal, bypass, zero-length request with high address bits
    put_desc('h00, 8'h81, 16'h0040, 36'h0_0000_0010, 36'h0_0000_1000, 1'b0, 1'b0);
    put_desc('h10, 8'h05, 16'h0008, 36'h0_0000_0020, 36'h0_0000_2000, 1'b0, 1'b0);
    put_desc('h20, 8'h81, 16'h0003, 36'h0_0000_0000, 36'h5_0000_3000, 1'b1, 1'b0);
    expect_ev(K_XFER, xf(1'b0, 16'h0040, 36'h1000), "R5");
    expect_ev(K_DONE, dn(1'b1, 36'h10), "R6");
    expect_ev(K_DONE, dn(1'b0, 36'h20), "R7");
    expect_ev(K_XFER, xf(1'b1, 16'h0003, 36'h5_0000_3000), "R5");
    expect_ev(K_DONE, dn(1'b1, 36'h00), "R6");
    start_addr = 36'h0;
    pulse(0);
    check(active == 1'b1, "R2", "active after start", {63'b0, active}, 64'd1);
    begin
      int n;
      n = 0;
      for (int i = 0; i < 12 && n < 4; i++) begin
        @(negedge clk);
        if (mem_req && !mem_we) begin
          check(mem_addr == ADDR_W'(4*n), "R2", "fetch word address", {28'b0, mem_addr}, 64'(4*n));
          n++;
        end
      end
      check(n == 4, "R2", "fetch word count", 64'(n), 64'd4);
    end
    drain("R6");
    repeat (12) @(negedge clk);
    check(mem[0] == (w0_save[0] & ~32'h1), "R6", "writeback word0 desc0", {32'b0, mem[0]}, {32'b0, w0_save[0] & ~32'h1});
    check(mem[4] == (w0_save[4] & ~32'h1), "R7", "writeback word0 bypass", {32'b0, mem[4]}, {32'b0, w0_save[4] & ~32'h1});
    check(mem[8] == (w0_save[8] & ~32'h1), "R6", "writeback word0 desc2", {32'b0, mem[8]}, {32'b0, w0_save[8] & ~32'h1});
    // R3 stalled at the released descriptor 0
    check(active == 1'b1, "R3", "active while stalled", {63'b0, active}, 64'd1);
    check(cur_addr == 36'h0, "R3", "pointer held at stall", {28'b0, cur_addr}, 64'd0);
    put_desc('h00, 8'h81, 16'h0040, 36'h0_0000_0010, 36'h0_0000_1000, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check(cur_addr == 36'h0 && !xfer_valid, "R3", "no progress without resume", {28'b0, cur_addr}, 64'd0);
    expect_ev(K_XFER, xf(1'b0, 16'h0040, 36'h1000), "R3");
    expect_ev(K_DONE, dn(1'b1, 36'h10), "R3");
    pulse(2);
    drain("R3");
    repeat (12) @(negedge clk);
    check(cur_addr == 36'h10 && active, "R3", "stall at released desc1", {28'b0, cur_addr}, 64'h10);
    // R9 stop while stalled
    @(negedge clk);
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
    check(active == 1'b0, "R9", "stop while stalled", {63'b0, active}, 64'd0);

    // R4 checksum mismatch
    put_desc('h30, 8'h01, 16'h0004, 36'h40, 36'h8000, 1'b0, 1'b1);
    expect_ev(K_CKE, 64'h30, "R4");
    start_addr = 36'h30;
    pulse(0);
    drain("R4");
    check(active == 1'b0 && cur_addr == 36'h30, "R4", "halt at bad desc", {27'b0, active, cur_addr}, 64'h30);
    check(mem[12][0] == 1'b1, "R4", "ownership kept", {63'b0, mem[12][0]}, 64'd1);

    // R10 bypass with bad checksum still reports checksum fault
    put_desc('h40, 8'h05, 16'h0004, 36'h50, 36'h8000, 1'b0, 1'b1);
    expect_ev(K_CKE, 64'h40, "R10");
    start_addr = 36'h40;
    pulse(0);
    drain("R10");

    // R8 transmit zero length
    put_desc('h50, 8'h81, 16'h0000, 36'h60, 36'h9000, 1'b0, 1'b0);
    expect_ev(K_LNE, 64'h50, "R8");
    start_addr = 36'h50;
    pulse(0);
    drain("R8");
    check(active == 1'b0 && cur_addr == 36'h50, "R8", "halt at zero length", {27'b0, active, cur_addr}, 64'h50);
    check(mem[20][0] == 1'b1, "R8", "ownership kept on length fault", {63'b0, mem[20][0]}, 64'd1);
    // repaired as bypass and resumed
    put_desc('h50, 8'h85, 16'h0000, 36'h60, 36'h9000, 1'b0, 1'b0);
    expect_ev(K_DONE, dn(1'b1, 36'h60), "R7");
    pulse(2);
    drain("R7");
    repeat (12) @(negedge clk);
    pulse(1);
    check(active == 1'b0, "R9", "stopped at empty desc", {63'b0, active}, 64'd0);

    // R8 receive zero length moves normally, next pointer high bits
    tx_mode = 1'b0;
    put_desc('h80, 8'h01, 16'h0000, 36'hA_0000_0090, 36'h4000, 1'b0, 1'b0);
    expect_ev(K_XFER, xf(1'b0, 16'h0000, 36'h4000), "R8");
    expect_ev(K_DONE, dn(1'b0, 36'hA_0000_0090), "R6");
    start_addr = 36'h80;
    pulse(0);
    drain("R8");
    repeat (12) @(negedge clk);
    pulse(1);

    // R9 stop during a transfer
    tx_mode = 1'b1;
    put_desc('h60, 8'h01, 16'h0010, 36'h70, 36'h6000, 1'b0, 1'b0);
    put_desc('h70, 8'h01, 16'h0010, 36'h80, 36'h7000, 1'b0, 1'b0);
    expect_ev(K_XFER, xf(1'b0, 16'h0010, 36'h6000), "R9");
    expect_ev(K_DONE, dn(1'b0, 36'h70), "R9");
    start_addr = 36'h60;
    pulse(0);
    for (int i = 0; i < 40 && !xfer_valid; i++) @(negedge clk);
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
    drain("R9");
    check(active == 1'b0 && cur_addr == 36'h70, "R9", "stop after current desc", {27'b0, active, cur_addr}, 64'h70);
    check(mem[28][0] == 1'b1, "R9", "next desc untouched", {63'b0, mem[28][0]}, 64'd1);

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule